// File: doc/BRIEF.md
# Programmable Frequency Output Divider

This block turns one of two timebase enable pulses into a square-wave frequency output that can be routed to trigger pins. Both timebases arrive as single-cycle enables in the system clock domain. Software picks the source, can halve the fast source first, and chooses a 4-bit divide ratio. The encoding of that ratio lets a field of zero mean the largest ratio, sixteen.

All configuration comes in through one write strobe that carries every field at once. The enable field starts and stops the output. A divide value written while the output is running goes into a shadow register and is not used until the output is switched off and on again. The safe way to change the ratio is therefore: disable, write the new ratio, enable.

Top module: `freq_out_div`

## Requirements
- R1: The divide field D (4 bits) sets the ratio N = D for D = 1..15 and N = 16 for D = 0; with N >= 2 the output repeats every N counted timebase pulses.
- R2: For N >= 2 the output goes high on the first counted pulse after enabling. It stays high for ceil(N/2) counted pulses and low for the remaining N - ceil(N/2). It updates in the clock cycle after the counted pulse.
- R3: With N = 1 the output is high exactly in the cycle after each counted pulse and low otherwise.
- R4: When the enable field is written as 0, the output is low from the second cycle after the write cycle and the divider phase is reset. The next enable starts again at the beginning of the high phase.
- R5: A divide value written while enable is already 1 does not change the running ratio. The ratio last written takes effect at the next 0-to-1 transition of enable.
- R6: The source select field uses 0 for the fast timebase and 1 for the second timebase. Pulses on the timebase that is not selected do not change the output.
- R7: With the fast source selected and the halve field at 1, only every second fast pulse is counted, starting with the second one after enabling. With the second timebase selected, the halve field has no effect.
- R8: After reset the output is low and the block is disabled, so timebase pulses leave the output low.
- R9: A timebase pulse that arrives in the cycle right after the enabling write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fastTick | input | 1 | Fast timebase enable pulse |
| slowTick | input | 1 | Second timebase enable pulse |
| cfgWe | input | 1 | Configuration write strobe |
| cfgDivide | input | DIV_W (4) | Divide ratio field, 0 means 16 |
| cfgHalve | input | 1 | Halve the fast timebase before dividing |
| cfgSrcSel | input | 1 | Source select: 0 fast, 1 second timebase |
| cfgEnable | input | 1 | Run enable |
| freqOut | output | 1 | Divided frequency output |

## Verification
The assertions assume that each timebase pulse lasts a single cycle. They also assume that the source and halve settings are not rewritten while the output is running, because the check on halved pulses relies on the mode staying the same across consecutive cycles. The stimulus meets this by always disabling before it changes the source or halve setting. It raises each timebase line for exactly one cycle and never issues a counted pulse in the load cycle after enabling, except in the one directed test that checks that pulse is dropped.

// File: rtl/freq_div_pkg.sv
package freq_div_pkg;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic tick;   // counted timebase pulse
    logic clear;  // hold divider at phase zero, output low
  } fdStrobe_t;

endpackage

// File: rtl/freq_div_ctrl.sv
module freq_div_ctrl
  import freq_div_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastTick,
  input  logic             slowTick,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgDivide,
  input  logic             cfgHalve,
  input  logic             cfgSrcSel,
  input  logic             cfgEnable,
  output fdStrobe_t        strb,
  output logic [DIV_W-1:0] activeDiv,
  output logic             enQ,
  output logic             riseQ,
  output logic             halveQ,
  output logic             srcSelQ
);

  logic [DIV_W-1:0] shadowDiv;
  logic             halfPh;
  logic             fastSel;

  // Configuration capture; the enable rising edge is flagged for one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      srcSelQ   <= 1'b0;
      halveQ    <= 1'b0;
      shadowDiv <= '0;
      riseQ     <= 1'b0;
    end else begin
      riseQ <= cfgWe && cfgEnable && !enQ;
      if (cfgWe) begin
        enQ       <= cfgEnable;
        srcSelQ   <= cfgSrcSel;
        halveQ    <= cfgHalve;
        shadowDiv <= cfgDivide;
      end
    end
  end

  // Running ratio follows the shadow only in the load cycle after enabling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDiv <= '0;
    end else if (riseQ) begin
      activeDiv <= shadowDiv;
    end
  end

  // Fast-source halving phase, restarted whenever the block is idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfPh <= 1'b0;
    end else if (!enQ) begin
      halfPh <= 1'b0;
    end else if (fastTick) begin
      halfPh <= ~halfPh;
    end
  end

  always_comb begin
    fastSel    = halveQ ? (fastTick && halfPh) : fastTick;
    strb.tick  = enQ && !riseQ && (srcSelQ ? slowTick : fastSel);
    strb.clear = !enQ || riseQ;
  end

endmodule

// File: rtl/freq_div_dp.sv
module freq_div_dp
  import freq_div_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  fdStrobe_t        strb,
  input  logic [DIV_W-1:0] activeDiv,
  output logic             freqOut
);

  localparam int RW = DIV_W + 1;
  localparam logic [RW-1:0] MAX_RATIO = RW'(1 << DIV_W);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0]    ratio;
  logic [RW-1:0]    hiCnt;
  logic [DIV_W-1:0] cnt;
  logic             isOne;
  logic             atLast;

  always_comb begin
    ratio  = (activeDiv == '0) ? MAX_RATIO : {1'b0, activeDiv};
    hiCnt  = (ratio + ONE) >> 1;
    isOne  = (ratio == ONE);
    atLast = ({1'b0, cnt} == (ratio - ONE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      freqOut <= 1'b0;
    end else if (strb.clear) begin
      cnt     <= '0;
      freqOut <= 1'b0;
    end else if (isOne) begin
      freqOut <= strb.tick;
    end else if (strb.tick) begin
      freqOut <= ({1'b0, cnt} < hiCnt);
      cnt     <= atLast ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/freq_out_div.sv
module freq_out_div
  import freq_div_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fastTick,
  input  logic             slowTick,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgDivide,
  input  logic             cfgHalve,
  input  logic             cfgSrcSel,
  input  logic             cfgEnable,
  output logic             freqOut
);

  fdStrobe_t        strb;
  logic [DIV_W-1:0] activeDiv;
  logic             enQ;
  logic             riseQ;
  logic             halveQ;
  logic             srcSelQ;

  freq_div_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fastTick (fastTick),
    .slowTick (slowTick),
    .cfgWe    (cfgWe),
    .cfgDivide(cfgDivide),
    .cfgHalve (cfgHalve),
    .cfgSrcSel(cfgSrcSel),
    .cfgEnable(cfgEnable),
    .strb     (strb),
    .activeDiv(activeDiv),
    .enQ      (enQ),
    .riseQ    (riseQ),
    .halveQ   (halveQ),
    .srcSelQ  (srcSelQ)
  );

  freq_div_dp #(.DIV_W(DIV_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .activeDiv(activeDiv),
    .freqOut  (freqOut)
  );

endmodule

// File: rtl/freq_out_div_chk.sv
module freq_out_div_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enQ,
  input logic             riseQ,
  input logic             tick,
  input logic             clear,
  input logic             halveQ,
  input logic             srcSelQ,
  input logic [DIV_W-1:0] activeDiv,
  input logic             freqOut
);

  // R4: idle block drives the output low on the following cycle
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> !freqOut);

  // R2: above ratio one, the output only moves on a counted pulse or a clear
  a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ((freqOut != $past(freqOut)) && ($past(activeDiv) != DIV_W'(1)))
      |-> $past(tick || clear));

  // R5: running ratio is held except in the load cycle
  a_r5_ratio_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(riseQ) |-> $stable(activeDiv));

  // R7: halved fast pulses are never counted in back-to-back cycles
  a_r7_halve_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && halveQ && !srcSelQ) |=> !(tick && halveQ && !srcSelQ));

endmodule

bind freq_out_div freq_out_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enQ      (enQ),
  .riseQ    (riseQ),
  .tick     (strb.tick),
  .clear    (strb.clear),
  .halveQ   (halveQ),
  .srcSelQ  (srcSelQ),
  .activeDiv(activeDiv),
  .freqOut  (freqOut)
);

// File: tb/sim_freq_out_div.sv
module sim_freq_out_div;

  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rstN;
  logic fastTick, slowTick, cfgWe, cfgHalve, cfgSrcSel, cfgEnable;
  logic [DIV_W-1:0] cfgDivide;
  logic freqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  freq_out_div #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .slowTick(slowTick),
    .cfgWe(cfgWe), .cfgDivide(cfgDivide), .cfgHalve(cfgHalve),
    .cfgSrcSel(cfgSrcSel), .cfgEnable(cfgEnable), .freqOut(freqOut)
  );

  // Vector: {divide[3:0], srcSel, halve}
  localparam logic [5:0] VEC [0:7] = '{
    {4'd3, 1'b0, 1'b0}, {4'd4, 1'b0, 1'b0}, {4'd0, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b0}, {4'd5, 1'b1, 1'b0}, {4'd7, 1'b0, 1'b1},
    {4'd2, 1'b1, 1'b1}, {4'd15, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: freqOut=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write cycle
  task automatic wr(input logic en, input logic src, input logic hv,
                    input logic [DIV_W-1:0] dv);
    cfgWe = 1'b1; cfgEnable = en; cfgSrcSel = src; cfgHalve = hv; cfgDivide = dv;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // One-cycle pulse starting now; returns when the output reflects it
  task automatic pulse(input logic slow);
    if (slow) slowTick = 1'b1; else fastTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0; fastTick = 1'b0;
  endtask

  task automatic runCase(input logic [DIV_W-1:0] dv, input logic src, input logic hv);
    int n, hi, counted, total;
    logic exp, passed;
    n  = (dv == 0) ? 16 : int'(dv);
    hi = (n + 1) / 2;
    counted = 0;
    wr(1'b0, src, hv, dv);
    wr(1'b1, src, hv, dv);
    @(negedge clk);                     // skip the load cycle (R9)
    total = (hv && !src) ? 2 * (2 * n + 1) : 2 * n + 1;
    for (int j = 0; j < total; j++) begin
      passed = !(hv && !src) || (j % 2 == 1);
      if (passed) counted++;
      pulse(src);
      if (n == 1) exp = passed;
      else exp = (counted == 0) ? 1'b0 : (((counted - 1) % n) < hi);
      if (hv && !src) check("R7 halved fast source", freqOut, exp);
      else if (n == 1) check("R3 ratio one", freqOut, exp);
      else if (dv == 0) check("R1 zero field gives 16", freqOut, exp);
      else check("R2 duty and period", freqOut, exp);
      pulse(!src);                      // unselected timebase
      if (n == 1) exp = 1'b0;
      if (hv && src) check("R7 halve ignored on second timebase", freqOut, exp);
      else check("R6 unselected source ignored", freqOut, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; fastTick = 0; slowTick = 0; cfgWe = 0;
    cfgHalve = 0; cfgSrcSel = 0; cfgEnable = 0; cfgDivide = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset output low", freqOut, 1'b0);
    pulse(1'b0);
    check("R8 disabled after reset ignores fast", freqOut, 1'b0);
    pulse(1'b1);
    check("R8 disabled after reset ignores slow", freqOut, 1'b0);

    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      runCase(v[5:2], v[1], v[0]);
    end

    // R4: disable while high, then restart from phase zero
    wr(1'b0, 1'b0, 1'b0, 4'd4);
    wr(1'b1, 1'b0, 1'b0, 4'd4);
    @(negedge clk);
    pulse(1'b0);
    check("R4 first pulse high", freqOut, 1'b1);
    wr(1'b0, 1'b0, 1'b0, 4'd4);
    @(negedge clk);
    check("R4 output low after disable", freqOut, 1'b0);
    wr(1'b1, 1'b0, 1'b0, 4'd4);
    @(negedge clk);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    check("R4 third pulse low at ratio 4", freqOut, 1'b0);
    wr(1'b0, 1'b0, 1'b0, 4'd4);
    wr(1'b1, 1'b0, 1'b0, 4'd4);
    @(negedge clk);
    pulse(1'b0);
    check("R4 restart at high phase", freqOut, 1'b1);

    // R5: divide written while running is deferred
    wr(1'b0, 1'b0, 1'b0, 4'd2);
    wr(1'b1, 1'b0, 1'b0, 4'd2);
    @(negedge clk);
    wr(1'b1, 1'b0, 1'b0, 4'd6);
    pulse(1'b0);
    check("R5 old ratio kept tick1", freqOut, 1'b1);
    pulse(1'b0);
    check("R5 old ratio kept tick2", freqOut, 1'b0);
    pulse(1'b0);
    check("R5 old ratio kept tick3", freqOut, 1'b1);
    wr(1'b0, 1'b0, 1'b0, 4'd6);
    wr(1'b1, 1'b0, 1'b0, 4'd6);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      pulse(1'b0);
      check("R5 new ratio after re-enable", freqOut, (k < 3));
    end

    // R9: pulse in the load cycle is dropped
    wr(1'b0, 1'b0, 1'b0, 4'd4);
    wr(1'b1, 1'b0, 1'b0, 4'd4);
    pulse(1'b0);
    check("R9 load-cycle pulse ignored", freqOut, 1'b0);
    pulse(1'b0);
    check("R9 next pulse counted", freqOut, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule